// File: doc/BRIEF.md
# Minimum-mode bus cycle sequencer

This block turns single transfer requests from an internal requester into timed cycles on a 16-bit multiplexed address/data bus. A cycle moves through the T-states T1, T2, T3, any number of wait states TW, and T4. There are three kinds of transfer: memory or I/O read, memory or I/O write, and interrupt acknowledge. The outputs are the address-latch strobe, the read, write and acknowledge strobes (active low), the memory/IO select, the active-low byte-high enable, the transceiver direction and the active-low transceiver enable. An output-enable signal controls the shared lines.

Some events fall in the middle of a T-state. These are the late read strobe in T2 and the end of write data in T4. A falling-edge phase register tracks them, so only one clock is needed. A requester presents a request while `req_ready_o` is high. It receives a one-cycle `done_o` pulse with the captured data after T4. An acknowledge request runs as two bus cycles back to back. The data byte is taken in the second cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: Out of reset and while idle, `ale_o` is 0, `rd_n_o`, `wr_n_o`, `inta_n_o`, `den_n_o` and `bhe_n_o` are 1, `ad_oe_o`, `dt_r_o`, `m_io_o` and `done_o` are 0, and `req_ready_o` is 1.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1, and T1 spans the following cycle. `ale_o` is 1 during T1 only. For read (`req_kind_i`=00) and write (01), `ad_o` carries the address with `ad_oe_o`=1 in T1.
- R3: `m_io_o` equals the request's `req_mem_i`, and `bhe_n_o` equals the inverse of `req_bhe_i`. Both hold unchanged from T1 through T4.
- R4: In a read, `ad_oe_o` is 0 from the start of T2. `rd_n_o` goes low at the falling clock edge in the middle of T2, stays low through T3 and every TW, and is high in T4.
- R5: In a write, `wr_n_o` is low from the start of T2 through T3 and every TW. `ad_o` carries the write data with `ad_oe_o`=1 from the start of T2 until the falling edge in the middle of T4.
- R6: `ready_i` is sampled at the clock edge that ends T3 and at the edge that ends each TW. A 0 adds one TW, and a 1 moves to T4.
- R7: An acknowledge request (`req_kind_i`=10) runs two complete T1–T4 cycles back to back. `ale_o` pulses in each T1, `inta_n_o` follows the `rd_n_o` timing of R4, and `ad_oe_o` stays 0 throughout, T1 included.
- R8: `dt_r_o` is 1 for a write and 0 for a read or acknowledge, from T1 through T4. `den_n_o` is low while the read or acknowledge strobe is low. For a write it is low from the start of T2 until the middle of T4.
- R9: `done_o` is 1 for exactly the one cycle after the final T4. At the same time `rdata_o` holds `ad_i` as sampled at the edge that ended the final T3/TW. For an acknowledge this value is zero-extended from its low byte, taken in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 2 | 00 read, 01 write, 10 interrupt acknowledge |
| req_addr_i | input | 16 | Transfer address |
| req_wdata_i | input | 16 | Write data |
| req_mem_i | input | 1 | 1 memory, 0 I/O |
| req_bhe_i | input | 1 | Upper byte lane enabled |
| req_ready_o | output | 1 | Sequencer idle, request may be accepted |
| ready_i | input | 1 | Device ready, low stretches the cycle |
| ad_i | input | 16 | Multiplexed lines, inbound |
| ad_o | output | 16 | Multiplexed lines, outbound |
| ad_oe_o | output | 1 | Drive enable for the multiplexed lines |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| inta_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| m_io_o | output | 1 | Memory/IO select |
| bhe_n_o | output | 1 | Byte-high enable, active low |
| dt_r_o | output | 1 | Transceiver direction, 1 transmit |
| den_n_o | output | 1 | Transceiver enable, active low |
| done_o | output | 1 | Request complete pulse |
| rdata_o | output | 16 | Captured read or acknowledge data |

## Verification
The bench uses the default 16-bit data width. It sweeps all three transfer kinds, both memory and I/O, both byte-high settings and zero to three wait states per bus cycle, which gives 48 requests. Outputs are sampled in both halves of every T-state. This covers the mid-T2 read strobe, the mid-T4 release of the write data, and wait states in both halves of an acknowledge pair. The inbound data differs between the two acknowledge cycles, so a capture from the first cycle is caught.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5
  } tstate_e;

  localparam logic [1:0] K_READ  = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_INTA  = 2'b10;
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    pair_i,
  input  logic    ready_i,
  output tstate_e st_o,
  output logic    capture_o,
  output logic    done_o
);
  tstate_e st_d;
  logic    second_q;
  logic    repeat_cyc;

  assign repeat_cyc = pair_i && !second_q;

  always_comb begin
    st_d = st_o;
    unique case (st_o)
      S_IDLE:      if (start_i) st_d = S_T1;
      S_T1:        st_d = S_T2;
      S_T2:        st_d = S_T3;
      S_T3, S_TW:  st_d = ready_i ? S_T4 : S_TW;
      S_T4:        st_d = repeat_cyc ? S_T1 : S_IDLE;
      default:     st_d = S_IDLE;
    endcase
  end

  // last data phase of the request
  assign capture_o = ((st_o == S_T3) || (st_o == S_TW)) && ready_i && !repeat_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o     <= S_IDLE;
      second_q <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      st_o   <= st_d;
      done_o <= (st_o == S_T4) && !repeat_cyc;
      if (st_o == S_T4) second_q <= repeat_cyc;
    end
  end

  p_wait_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((st_o == S_T3) || (st_o == S_TW)) && !ready_i) |=> (st_o == S_TW));
  p_wait_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((st_o == S_T3) || (st_o == S_TW)) && ready_i) |=> (st_o == S_T4));
  p_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_o == S_T4) && pair_i && !second_q) |=> ((st_o == S_T1) && second_q));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st_o == S_IDLE));
endmodule

// File: rtl/bcs_req.sv
module bcs_req
  import bcs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mem_i,
  input  logic              bhe_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [1:0]        kind_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              mem_o,
  output logic              bhe_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] cap_val;

  always_comb begin
    cap_val = ad_i;
    if (kind_o == K_INTA) cap_val = {{(DATA_W-BYTE_W){1'b0}}, ad_i[BYTE_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o  <= K_READ;
      addr_o  <= '0;
      wdata_o <= '0;
      mem_o   <= 1'b0;
      bhe_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (start_i) begin
        kind_o  <= kind_i;
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
        mem_o   <= mem_i;
        bhe_o   <= bhe_i;
      end
      if (capture_i) rdata_o <= cap_val;
    end
  end

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> ($stable(mem_o) && $stable(bhe_o) && $stable(kind_o)));
endmodule

// File: rtl/bcs_strobe.sv
module bcs_strobe
  import bcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  tstate_e    st_i,
  input  logic [1:0] kind_i,
  output logic       ale_o,
  output logic       rd_n_o,
  output logic       wr_n_o,
  output logic       inta_n_o,
  output logic       den_n_o,
  output logic       dt_r_o,
  output logic       ad_oe_o,
  output logic       addr_phase_o
);
  tstate_e st_neg_q;  // T-state seen at the mid-cycle falling edge
  logic    busy, is_wr, is_ack, in_data, late_win, wr_hold;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_neg_q <= S_IDLE;
    else         st_neg_q <= st_i;
  end

  assign busy    = (st_i != S_IDLE);
  assign is_wr   = (kind_i == K_WRITE);
  assign is_ack  = (kind_i == K_INTA);
  assign in_data = (st_i == S_T2) || (st_i == S_T3) || (st_i == S_TW);
  // read-type strobe opens half way into T2
  assign late_win = ((st_i == S_T2) && (st_neg_q == S_T2)) || (st_i == S_T3) || (st_i == S_TW);
  // write data held for the first half of T4
  assign wr_hold  = (st_i == S_T4) && (st_neg_q != S_T4);

  assign addr_phase_o = (st_i == S_T1);
  assign ale_o    = addr_phase_o;
  assign rd_n_o   = !(late_win && !is_wr && !is_ack);
  assign inta_n_o = !(late_win && is_ack);
  assign wr_n_o   = !(in_data && is_wr);
  assign ad_oe_o  = (addr_phase_o && !is_ack) || (is_wr && (in_data || wr_hold));
  assign den_n_o  = is_wr ? !(in_data || wr_hold) : !late_win;
  assign dt_r_o   = busy && is_wr;

  p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!rd_n_o, !wr_n_o, !inta_n_o}));
  p_rd_float_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !inta_n_o) |-> !ad_oe_o);
  p_ale_alone_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_n_o && wr_n_o && inta_n_o));
  p_ack_float_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && is_ack) |-> !ad_oe_o);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_mem_i,
  input  logic              req_bhe_i,
  output logic              req_ready_o,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              inta_n_o,
  output logic              m_io_o,
  output logic              bhe_n_o,
  output logic              dt_r_o,
  output logic              den_n_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  tstate_e           st;
  logic              start, capture, busy, addr_phase, mem_q, bhe_q;
  logic [1:0]        kind_q;
  logic [DATA_W-1:0] addr_q, wdata_q;

  assign busy        = (st != S_IDLE);
  assign req_ready_o = !busy;
  assign start       = req_valid_i && req_ready_o;

  bcs_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .pair_i    (kind_q == K_INTA),
    .ready_i   (ready_i),
    .st_o      (st),
    .capture_o (capture),
    .done_o    (done_o)
  );

  bcs_req #(.DATA_W(DATA_W)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .kind_i    (req_kind_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .mem_i     (req_mem_i),
    .bhe_i     (req_bhe_i),
    .capture_i (capture),
    .ad_i      (ad_i),
    .kind_o    (kind_q),
    .addr_o    (addr_q),
    .wdata_o   (wdata_q),
    .mem_o     (mem_q),
    .bhe_o     (bhe_q),
    .rdata_o   (rdata_o)
  );

  bcs_strobe u_strobe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .st_i         (st),
    .kind_i       (kind_q),
    .ale_o        (ale_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o),
    .inta_n_o     (inta_n_o),
    .den_n_o      (den_n_o),
    .dt_r_o       (dt_r_o),
    .ad_oe_o      (ad_oe_o),
    .addr_phase_o (addr_phase)
  );

  assign ad_o    = addr_phase ? addr_q : wdata_q;
  assign m_io_o  = busy && mem_q;
  assign bhe_n_o = !(busy && bhe_q);

  p_sel_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(m_io_o) && $stable(bhe_n_o) && $stable(dt_r_o)));
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ale_o);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (rd_n_o && wr_n_o && inta_n_o && den_n_o && !ad_oe_o && !ale_o));
endmodule

// File: tb/bus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = 2'b00;
  logic [15:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_mem_i = 1'b0;
  logic        req_bhe_i = 1'b0;
  logic        req_ready_o;
  logic        ready_i = 1'b1;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o;
  logic        ad_oe_o, ale_o, rd_n_o, wr_n_o, inta_n_o, m_io_o, bhe_n_o, dt_r_o, den_n_o, done_o;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_cycle_seq dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [15:0] in_word(input int p, input logic [15:0] a, input logic [15:0] w);
    return (p == 0) ? {a[7:0] ^ 8'h33, 8'hC3} : {8'h77, a[15:8] ^ w[7:0]};
  endfunction

  task automatic run_req(input int k, input bit mem, input bit bhe,
                         input logic [15:0] addr, input logic [15:0] wdata, input int waits);
    int npass;
    logic [15:0] exp_rd;
    npass = (k == 2) ? 2 : 1;
    @(negedge clk_i);
    chk("R2", "req_ready", req_ready_o, 1);
    req_valid_i = 1'b1; req_kind_i = k[1:0]; req_addr_i = addr; req_wdata_i = wdata;
    req_mem_i = mem; req_bhe_i = bhe; ready_i = 1'b1;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    for (int p = 0; p < npass; p++) begin
      if (p > 0) begin @(posedge clk_i); #1; end
      // T1
      chk("R2", "ale T1", ale_o, 1);
      chk("R3", "m_io T1", m_io_o, mem);
      chk("R3", "bhe_n T1", bhe_n_o, !bhe);
      chk(k == 2 ? "R7" : "R2", "oe T1", ad_oe_o, k != 2);
      if (k != 2) chk("R2", "addr T1", ad_o, addr);
      chk("R8", "dt_r T1", dt_r_o, k == 1);
      chk("R4", "strobes T1", {rd_n_o, wr_n_o, inta_n_o}, 3'b111);
      // T2 first half
      @(posedge clk_i); #1;
      chk("R2", "ale T2", ale_o, 0);
      chk("R4", "rd_n early T2", rd_n_o, 1);
      chk("R7", "inta_n early T2", inta_n_o, 1);
      chk("R5", "wr_n T2", wr_n_o, k != 1);
      chk("R4", "oe T2", ad_oe_o, k == 1);
      if (k == 1) chk("R5", "wdata T2", ad_o, wdata);
      // T2 second half
      @(negedge clk_i); #1;
      chk("R4", "rd_n late T2", rd_n_o, k != 0);
      chk("R7", "inta_n late T2", inta_n_o, k != 2);
      chk("R8", "den_n late T2", den_n_o, 0);
      ready_i = (waits == 0);
      ad_i = in_word(p, addr, wdata);
      // T3
      @(posedge clk_i); #1;
      chk("R6", "strobe T3", {rd_n_o, wr_n_o, inta_n_o},
          k == 0 ? 3'b011 : (k == 1 ? 3'b101 : 3'b110));
      chk("R8", "den_n T3", den_n_o, 0);
      for (int w = 0; w < waits; w++) begin
        @(posedge clk_i); #1;
        chk("R6", "strobe TW", {rd_n_o, wr_n_o, inta_n_o},
            k == 0 ? 3'b011 : (k == 1 ? 3'b101 : 3'b110));
        chk("R3", "m_io TW", m_io_o, mem);
        if (k == 1) chk("R5", "wdata TW", ad_o, wdata);
        ready_i = (w == waits - 1);
      end
      // T4 first half
      @(posedge clk_i); #1;
      ready_i = 1'b1;
      ad_i = 16'hDEAD;
      chk("R6", "strobes T4", {rd_n_o, wr_n_o, inta_n_o}, 3'b111);
      chk("R5", "oe early T4", ad_oe_o, k == 1);
      chk("R8", "den_n early T4", den_n_o, k != 1);
      chk("R3", "bhe_n T4", bhe_n_o, !bhe);
      chk("R8", "dt_r T4", dt_r_o, k == 1);
      // T4 second half
      @(negedge clk_i); #1;
      chk("R5", "oe late T4", ad_oe_o, 0);
      chk("R8", "den_n late T4", den_n_o, 1);
      chk("R9", "no early done", done_o, 0);
    end
    @(posedge clk_i); #1;
    chk("R9", "done", done_o, 1);
    exp_rd = (k == 2) ? {8'h00, in_word(1, addr, wdata)[7:0]} : in_word(0, addr, wdata);
    if (k == 0) chk("R9", "read data", rdata_o, exp_rd);
    if (k == 2) chk("R7", "ack byte", rdata_o, exp_rd);
    chk("R1", "idle strobes", {rd_n_o, wr_n_o, inta_n_o, ad_oe_o, ale_o}, 5'b11100);
    @(posedge clk_i); #1;
    chk("R9", "done one cycle", done_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    #1;
    chk("R1", "reset strobes", {ale_o, rd_n_o, wr_n_o, inta_n_o, den_n_o, bhe_n_o}, 6'b011111);
    chk("R1", "reset misc", {ad_oe_o, dt_r_o, m_io_o, done_o, req_ready_o}, 5'b00001);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1", "idle after reset", {ale_o, rd_n_o, wr_n_o, inta_n_o, den_n_o, ad_oe_o}, 6'b011110);
    for (int k = 0; k < 3; k++)
      for (int m = 0; m < 2; m++)
        for (int b = 0; b < 2; b++)
          for (int w = 0; w < 4; w++)
            run_req(k, m[0], b[0], 16'(16'h1357 * (k + 1) + 16'h0421 * (m + 2 * b) + w),
                    16'(16'hA5C3 ^ (k * 16'h0111) ^ (w * 16'h1010) ^ (b * 16'h0808)), w);
    finish_run();
  end
endmodule